// File: doc/BRIEF.md
# Strobe Watchdog with Latched Status

This block guards a processor against runaway software. Software is expected to pull a strobe line from high to low at regular intervals. If no such falling edge arrives within a configured number of timing ticks, the block sends a one-cycle timeout request to the reset generator. It also drives an active-low status flag low, and that flag stays low as a record of the event. The timing ticks come from a clock-enable input, so the period is independent of the core clock rate.

The watchdog counts only while three conditions hold: the strobe is marked as present, the supply is in tolerance, and the reset generator reports that its reset outputs are inactive. A board that leaves the strobe undriven de-asserts the present input, which disables the watchdog and releases the status flag. A low supply forces the status flag active and stops the count. After a timeout the counter waits. It starts a fresh period once the reset stretch has come and gone, or once software strobes again.

The strobe is asynchronous to the clock. It passes through a flop synchroniser before its falling edge is detected.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst_n` is low, `status_n` is 1 and `timeout_pulse` is 0.
- R2: When the watchdog is enabled and no strobe falling edge arrives, `timeout_pulse` rises after the clock edge on which the PERIOD_TICKS-th tick is counted. With `tick` held at 1 and counting starting at the first edge, this is PERIOD_TICKS cycles. `status_n` goes to 0 on that same edge.
- R3: `timeout_pulse` is high for exactly one clock cycle per timeout.
- R4: A strobe falling edge clears the count, so strobe falling edges spaced closer than the period never produce a timeout. After the last falling edge, the next timeout comes PERIOD_TICKS ticks after the count is cleared.
- R5: A rising edge of the strobe does not restart the count.
- R6: Once low, `status_n` stays low until a strobe falling edge arrives (or the strobe is marked absent). A return of the supply and a reset stretch both leave it low.
- R7: While `strobe_present` is 0, no timeout occurs and `status_n` returns to 1 on the next clock edge unless `supply_low` is 1.
- R8: While `supply_low` is 1, no timeout occurs and `status_n` is 0 from the next clock edge.
- R9: No count advances while `rst_released` is 0. After a timeout, no further timeout is issued until `rst_released` has been 0 for at least one edge, or a strobe falling edge arrives. Either event starts a new full period.
- R10: A strobe falling edge driven on the input clears `status_n` to 1 on the third clock edge after it, because of the two synchroniser stages and the edge register.
- R11: The count advances only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing clock-enable; one count per high cycle |
| strobe_in | input | 1 | Asynchronous software strobe; falling edge restarts the period |
| strobe_present | input | 1 | 1 when the strobe is driven; 0 disables the watchdog |
| supply_low | input | 1 | 1 while the supply is below its trip point |
| rst_released | input | 1 | 1 while the reset generator's outputs are inactive |
| timeout_pulse | output | 1 | One-cycle request to the reset generator |
| status_n | output | 1 | Latched active-low watchdog status |

## Verification
A counter that is off by one shows directly at the ports: the timeout pulse arrives one cycle early or late against the tick count. A missing clear on a falling edge shows as a stray pulse during regular strobing. A hold state that never exits shows as a missing second pulse after the reset stretch. A status latch that drops the record early shows as `status_n` going high without a falling edge, within a cycle of the input change. A mistake in the synchroniser depth moves the status release away from the third edge, and the bench checks that edge exactly.

// File: rtl/wdt_pkg.sv
// Package: shared types for the strobe watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package wdt_pkg;
    // Counter phase: counting a period, or waiting after an issued timeout.
    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_WAIT  = 1'b1
    } wdt_phase_t;
endpackage

// File: rtl/wdt_strobe_edge.sv
// Module: wdt_strobe_edge
// Brings the asynchronous strobe into the clock domain through SYNC_STAGES
// flops, then flags a high-to-low transition of the synchronised level.
// Assumes: strobe_in is asynchronous; the flops reset to 0, so no false
// falling edge appears when reset is released.
module wdt_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fall_seen
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            // One synchroniser stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[gi] <= 1'b0;
                end else if (gi == 0) begin
                    chain_q[gi] <= strobe_in;
                end else begin
                    chain_q[gi] <= chain_q[(gi > 0) ? gi - 1 : 0];
                end
            end
        end
    endgenerate

    // Previous synchronised level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain_q[SYNC_STAGES-1];
        end
    end

    // Falling edge: was high, now low.
    always_comb begin
        fall_seen = last_q & ~chain_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/wdt_period_counter.sv
// Module: wdt_period_counter
// Counts ticks while enabled and signals expiry on the PERIOD_TICKS-th tick.
// After an expiry it waits until it is disabled (e.g. the reset stretch) or
// restarted by a strobe edge, then begins a new full period.
// Assumes: restart has priority over expiry in the same cycle.
module wdt_period_counter
    import wdt_pkg::*;
#(
    parameter int PERIOD_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic restart,
    output logic expire,
    output logic pulse_q
);
    localparam int CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

    logic [CNT_W-1:0] count_q;
    wdt_phase_t       phase_q;

    // Expiry: counting, enabled, no restart, tick on the last count.
    always_comb begin
        expire = (phase_q == PH_COUNT) && enable && !restart && tick
                 && (count_q == LAST);
    end

    // Count and phase update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            phase_q <= PH_COUNT;
        end else if (!enable || restart) begin
            count_q <= '0;
            phase_q <= PH_COUNT;
        end else if (phase_q == PH_COUNT && tick) begin
            if (count_q == LAST) begin
                count_q <= '0;
                phase_q <= PH_WAIT;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // Registered one-cycle timeout request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= expire;
        end
    end
endmodule

// File: rtl/wdt_status_latch.sv
// Module: wdt_status_latch
// Holds the active-low watchdog status. Priority: low supply forces it
// active, then expiry sets it, then a strobe edge or an absent strobe clears it.
// Assumes: inputs are synchronous to clk.
module wdt_status_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic expire,
    input  logic strobe_fall,
    input  logic strobe_present,
    output logic status_n
);
    // Latch update with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_n <= 1'b1;
        end else if (supply_low) begin
            status_n <= 1'b0;
        end else if (expire) begin
            status_n <= 1'b0;
        end else if (strobe_fall || !strobe_present) begin
            status_n <= 1'b1;
        end
    end
endmodule

// File: rtl/strobe_watchdog.sv
// Module: strobe_watchdog (top)
// Watchdog that requests a reset when software stops producing strobe
// falling edges, with a latched active-low status flag.
// Assumes: tick is a clock enable from a slower timebase; rst_released
// comes from the reset generator and is low during its reset stretch.
module strobe_watchdog #(
    parameter int PERIOD_TICKS = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic strobe_in,
    input  logic strobe_present,
    input  logic supply_low,
    input  logic rst_released,
    output logic timeout_pulse,
    output logic status_n
);
    logic fall_raw;
    logic fall_ok;
    logic run_en;
    logic expire;

    // Qualify the edge with presence and form the count enable.
    always_comb begin
        fall_ok = fall_raw & strobe_present;
        run_en  = strobe_present & ~supply_low & rst_released;
    end

    wdt_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (strobe_in),
        .fall_seen (fall_raw)
    );

    wdt_period_counter #(.PERIOD_TICKS(PERIOD_TICKS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (run_en),
        .restart (fall_ok),
        .expire  (expire),
        .pulse_q (timeout_pulse)
    );

    wdt_status_latch u_stat (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_low     (supply_low),
        .expire         (expire),
        .strobe_fall    (fall_ok),
        .strobe_present (strobe_present),
        .status_n       (status_n)
    );
endmodule

// File: rtl/wdt_checker.sv
// Module: wdt_checker
// Port-level properties of strobe_watchdog, attached by bind.
module wdt_checker (
    input logic clk,
    input logic rst_n,
    input logic strobe_present,
    input logic supply_low,
    input logic rst_released,
    input logic timeout_pulse,
    input logic status_n
);
    p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse);

    p_pulse_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> !status_n);

    p_supply_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (!status_n && !timeout_pulse));

    p_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_present && !supply_low) |=> (status_n && !timeout_pulse));

    p_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_released |=> !timeout_pulse);

    p_status_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_n) |-> $past(!supply_low));
endmodule

bind strobe_watchdog wdt_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_present (strobe_present),
    .supply_low     (supply_low),
    .rst_released   (rst_released),
    .timeout_pulse  (timeout_pulse),
    .status_n       (status_n)
);

// File: tb/sim_strobe_watchdog.sv
`timescale 1ns/1ps
module sim_strobe_watchdog;
    localparam int P = 16;

    logic clk = 1'b0;
    logic rst_n, tick, strobe_in, strobe_present, supply_low, rst_released;
    logic timeout_pulse, status_n;
    int   checks = 0;
    int   failures = 0;
    int   tick_div = 1;
    int   cyc_cnt = 0;

    always #2.5 clk = ~clk;

    // Tick generator: high one cycle in every tick_div.
    always @(negedge clk) begin
        cyc_cnt = cyc_cnt + 1;
        tick = ((cyc_cnt % tick_div) == 0);
    end

    strobe_watchdog #(.PERIOD_TICKS(P), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .strobe_in(strobe_in),
        .strobe_present(strobe_present), .supply_low(supply_low),
        .rst_released(rst_released), .timeout_pulse(timeout_pulse),
        .status_n(status_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Cycles until timeout_pulse is seen, -1 if not within max.
    task automatic measure(input int max, output int n);
        n = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (timeout_pulse) begin
                n = i;
                break;
            end
        end
    endtask

    // Number of pulses seen over n cycles.
    task automatic count_pulses(input int n, output int pc);
        pc = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (timeout_pulse) pc++;
        end
    endtask

    task automatic t_reset;
        rst_n = 0; strobe_in = 1; strobe_present = 1; supply_low = 0;
        rst_released = 1;
        cyc(3);
        check(status_n == 1'b1, "R1 status", status_n, 1);
        check(timeout_pulse == 1'b0, "R1 pulse", timeout_pulse, 0);
        rst_n = 1;
    endtask

    task automatic t_basic;
        int n, pc;
        measure(4 * P, n);
        check(n == P, "R2 period", n, P);
        check(status_n == 1'b0, "R2 status", status_n, 0);
        cyc(1);
        check(timeout_pulse == 1'b0, "R3 width", timeout_pulse, 0);
        count_pulses(3 * P, pc);
        check(pc == 0, "R9 hold after timeout", pc, 0);
        check(status_n == 1'b0, "R6 latched", status_n, 0);
    endtask

    task automatic t_stretch;
        int n;
        rst_released = 0;
        cyc(5);
        check(status_n == 1'b0, "R6 through stretch", status_n, 0);
        check(timeout_pulse == 1'b0, "R9 no pulse in stretch", timeout_pulse, 0);
        rst_released = 1;
        measure(4 * P, n);
        check(n == P, "R9 new period", n, P);
    endtask

    task automatic t_fall_clear;
        int n;
        strobe_in = 0;
        cyc(2);
        check(status_n == 1'b0, "R10 not before third edge", status_n, 0);
        cyc(1);
        check(status_n == 1'b1, "R10 cleared on third edge", status_n, 1);
        measure(4 * P, n);
        check(n == P, "R4 period after fall", n, P);
    endtask

    task automatic t_rising;
        int n;
        strobe_in = 1;
        cyc(3);
        strobe_in = 0;
        cyc(8);
        strobe_in = 1;
        measure(4 * P, n);
        check(8 + n == P + 3, "R5 rise ignored", 8 + n, P + 3);
    endtask

    task automatic t_periodic;
        int pc = 0;
        for (int k = 0; k < 20; k++) begin
            int a, b;
            strobe_in = 0;
            count_pulses(4, a);
            strobe_in = 1;
            count_pulses(4, b);
            pc += a + b;
        end
        check(pc == 0, "R4 regular strobing", pc, 0);
        check(status_n == 1'b1, "R4 status clear", status_n, 1);
    endtask

    task automatic t_absent;
        int n, pc;
        measure(4 * P, n);
        check(status_n == 1'b0, "R7 setup timeout", status_n, 0);
        strobe_present = 0;
        cyc(1);
        check(status_n == 1'b1, "R7 released", status_n, 1);
        strobe_in = 0;
        count_pulses(3 * P, pc);
        check(pc == 0, "R7 no timeout", pc, 0);
        strobe_in = 1;
        cyc(3);
        strobe_present = 1;
        measure(4 * P, n);
        check(n == P, "R7 resume period", n, P);
    endtask

    task automatic t_supply;
        int n, pc;
        strobe_in = 0;
        cyc(3);
        strobe_in = 1;
        check(status_n == 1'b1, "R8 setup clear", status_n, 1);
        supply_low = 1;
        cyc(1);
        check(status_n == 1'b0, "R8 forced", status_n, 0);
        count_pulses(3 * P, pc);
        check(pc == 0, "R8 no timeout", pc, 0);
        supply_low = 0;
        cyc(1);
        check(status_n == 1'b0, "R6 latched after supply", status_n, 0);
        measure(4 * P, n);
        check(1 + n == P, "R8 resume period", 1 + n, P);
    endtask

    task automatic t_tick;
        int n;
        tick_div = 3;
        strobe_in = 0;
        measure(8 * P, n);
        check(n > 3 * (P - 1) && n <= 3 * P + 3, "R11 tick scaled", n, 3 * P);
        strobe_in = 1;
        tick_div = 1;
    endtask

    initial begin
        t_reset();
        t_basic();
        t_stretch();
        t_fall_clear();
        t_rising();
        t_periodic();
        t_absent();
        t_supply();
        t_tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule